// File: doc/BRIEF.md
# Fault Code Blinker

This block turns a 32-bit fault word, typically the address at which a processor crashed, into a pattern of light pulses on one LED so that a person or a photodiode can read it without any other interface. A single-cycle trigger latches the word and starts the display. Each bit, taken from the top bit downward, is announced by a dark interval followed by a lit pulse. A short pulse means 0 and a pulse three times as long means 1. After the lowest bit, a long dark pause separates one word from the next. The display then starts again from the top bit and repeats until reset.

All timing is counted in base units. A prescaler makes one unit out of a parameterised number of clock cycles. The nominal unit is 100 ms, which is 1000 ticks of 100 µs. Simulation sets the unit to a few cycles. The word is copied into a register when the trigger is accepted, so the source may change or be released afterwards. The busy output tells the surrounding logic that the display owns the LED.

Top module: `fault_code_blinker`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `led` is 0 and `busy` is 0.
- R2: Before the first trigger, `led` and `busy` stay 0 whatever `code_in` does.
- R3: The word on `code_in` is captured in the cycle in which `trig` is accepted. Changes to `code_in` after that do not alter the displayed pattern.
- R4: `busy` goes to 1 at the clock edge that accepts `trig` and stays 1 until reset.
- R5: Bits are displayed starting at bit 31 and ending at bit 0, one bit position per dark-plus-lit pair.
- R6: Every bit starts with `led` at 0 for exactly one base unit. The first dark unit begins at the edge that accepts the trigger.
- R7: After its dark unit, a bit value of 0 holds `led` at 1 for one base unit, and a bit value of 1 holds `led` at 1 for three base units.
- R8: After the lit pulse of bit 0, `led` stays 0 for ten base units. The word is then shown again from bit 31, and this repeats until reset.
- R9: A `trig` pulse while `busy` is 1 is ignored: the pattern continues without a restart and without a new capture.
- R10: One base unit lasts exactly `UNIT_CYCLES` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Start request; accepted only while idle |
| code_in | input | CODE_W (32) | Word to display |
| led | output | 1 | LED drive, active high |
| busy | output | 1 | High from the accepted trigger until reset |

## Verification
The bench targets the all-zero and all-one words, which give the shortest and the longest frames. It also uses a word with only the two end bits set, so a reversed bit order becomes visible. A design that shows bit 0 first, or that forgets to reload the top index after the pause, diverges within the first frame or at the second frame start. A retrigger with a new word in the middle of a frame exposes a design that restarts or recaptures; its pulse train jumps away from the original pattern. Because every cycle is compared, a unit one cycle too long or too short shows up as a drift at the very first edge of the light.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DARK  = 2'd1,
    PH_LIT   = 2'd2,
    PH_PAUSE = 2'd3
  } phase_e;

  // Lit length in units for one bit value
  function automatic int unsigned lit_units(input logic bit_val,
                                            input int unsigned zero_u,
                                            input int unsigned one_u);
    return bit_val ? one_u : zero_u;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width for values 0..n-1, never below one bit
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fcb_unit_timer.sv
module fcb_unit_timer #(
  parameter int unsigned UNIT_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic unit_tick
);
  import fcb_pkg::*;

  localparam int unsigned CW = cnt_width(UNIT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(UNIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign unit_tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || unit_tick) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // Two unit ends are never back to back when a unit spans several cycles
  assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (rst)
    (unit_tick && UNIT_CYCLES > 1) |=> !unit_tick);

endmodule

// File: rtl/fcb_code_latch.sv
module fcb_code_latch #(
  parameter int unsigned CODE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [CODE_W-1:0] code_in,
  output logic              start,
  output logic              busy,
  output logic [CODE_W-1:0] code_q
);

  // A trigger counts only while nothing is being shown
  assign start = trig && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      code_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      code_q <= code_in;
    end
  end

  assert_busy_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy);

  assert_code_held_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(code_q));

endmodule

// File: rtl/fcb_phase_fsm.sv
module fcb_phase_fsm #(
  parameter int unsigned CODE_W     = 32,
  parameter int unsigned DARK_UNITS = 1,
  parameter int unsigned ZERO_UNITS = 1,
  parameter int unsigned ONE_UNITS  = 3,
  parameter int unsigned GAP_UNITS  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              unit_tick,
  input  logic [CODE_W-1:0] code_q,
  output logic              led
);
  import fcb_pkg::*;

  localparam int unsigned MAXU = max4(DARK_UNITS, ZERO_UNITS, ONE_UNITS, GAP_UNITS);
  localparam int unsigned LW   = cnt_width(MAXU);
  localparam int unsigned BW   = cnt_width(CODE_W);
  localparam logic [BW-1:0] TOP_BIT = BW'(CODE_W - 1);

  phase_e        phase_q, phase_n;
  logic [BW-1:0] bit_q,   bit_n;
  logic [LW-1:0] left_q,  left_n;
  logic          led_q;
  logic          phase_end;   // last unit of the current phase is finishing

  assign phase_end = unit_tick && (left_q == '0);

  always_comb begin
    phase_n = phase_q;
    bit_n   = bit_q;
    left_n  = left_q;
    if (start) begin
      phase_n = PH_DARK;
      bit_n   = TOP_BIT;
      left_n  = LW'(DARK_UNITS - 1);
    end else if (unit_tick && !phase_end) begin
      left_n = left_q - 1'b1;
    end else if (phase_end) begin
      unique case (phase_q)
        PH_DARK: begin
          phase_n = PH_LIT;
          left_n  = LW'(lit_units(code_q[bit_q], ZERO_UNITS, ONE_UNITS) - 1);
        end
        PH_LIT: begin
          if (bit_q == '0) begin
            phase_n = PH_PAUSE;
            left_n  = LW'(GAP_UNITS - 1);
          end else begin
            phase_n = PH_DARK;
            bit_n   = bit_q - 1'b1;
            left_n  = LW'(DARK_UNITS - 1);
          end
        end
        PH_PAUSE: begin
          phase_n = PH_DARK;
          bit_n   = TOP_BIT;
          left_n  = LW'(DARK_UNITS - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      left_q  <= '0;
      led_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      bit_q   <= bit_n;
      left_q  <= left_n;
      led_q   <= (phase_n == PH_LIT);
    end
  end

  assign led = led_q;

  assert_led_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> !led_q);

  assert_lit_after_dark_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(led_q) |-> ($past(phase_q) == PH_DARK));

  assert_pause_after_bit0_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PAUSE && $past(phase_q) != PH_PAUSE) |-> ($past(bit_q) == '0));

  assert_restart_msb_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DARK && $past(phase_q) == PH_PAUSE) |-> (bit_q == TOP_BIT));

endmodule

// File: rtl/fault_code_blinker.sv
module fault_code_blinker #(
  parameter int unsigned CODE_W      = 32,
  parameter int unsigned UNIT_CYCLES = 10_000_000,
  parameter int unsigned DARK_UNITS  = 1,
  parameter int unsigned ZERO_UNITS  = 1,
  parameter int unsigned ONE_UNITS   = 3,
  parameter int unsigned GAP_UNITS   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [CODE_W-1:0] code_in,
  output logic              led,
  output logic              busy
);

  logic              start;
  logic              unit_tick;
  logic [CODE_W-1:0] code_q;

  fcb_code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .trig    (trig),
    .code_in (code_in),
    .start   (start),
    .busy    (busy),
    .code_q  (code_q)
  );

  fcb_unit_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .unit_tick (unit_tick)
  );

  fcb_phase_fsm #(
    .CODE_W     (CODE_W),
    .DARK_UNITS (DARK_UNITS),
    .ZERO_UNITS (ZERO_UNITS),
    .ONE_UNITS  (ONE_UNITS),
    .GAP_UNITS  (GAP_UNITS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .unit_tick (unit_tick),
    .code_q    (code_q),
    .led       (led)
  );

  assert_led_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
    led |-> busy);

endmodule

// File: tb/fault_code_blinker_tb.sv
module fault_code_blinker_tb;

  localparam int U = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic [31:0] code_in = '0;
  logic        led;
  logic        busy;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;   // 250 MHz

  fault_code_blinker #(.CODE_W(32), .UNIT_CYCLES(U)) u_dut (
    .clk(clk), .rst(rst), .trig(trig), .code_in(code_in), .led(led), .busy(busy)
  );

  // Frame length in units: per bit one dark unit plus 1 or 3 lit units, then 10 dark
  function automatic int frame_units(input logic [31:0] c);
    int s = 10;
    for (int i = 0; i < 32; i++) s += c[i] ? 4 : 2;
    return s;
  endfunction

  // Region of cycle n after the accepting edge: 0 dark before a bit, 1 lit, 2 pause
  function automatic int region(input logic [31:0] c, input int n);
    int u = (n / U) % frame_units(c);
    for (int i = 31; i >= 0; i--) begin
      if (u < 1) return 0;
      u -= 1;
      if (u < (c[i] ? 3 : 1)) return 1;
      u -= c[i] ? 3 : 1;
    end
    return 2;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp, input int n);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %b expected %b", req, n, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 led in reset", led, 1'b0, 0);
    chk("R1 busy in reset", busy, 1'b0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 led after reset", led, 1'b0, 0);
    chk("R1 busy after reset", busy, 1'b0, 0);
  endtask

  // Show one word for two frames; optionally retrigger with a new word mid-frame
  task automatic run_word(input logic [31:0] c, input bit retrig);
    int total;
    string tag;
    do_reset();
    // R2: idle with a wandering input word
    for (int k = 0; k < 12; k++) begin
      code_in = $urandom;
      @(negedge clk);
      chk("R2 idle led", led, 1'b0, k);
      chk("R2 idle busy", busy, 1'b0, k);
    end
    code_in = c;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    total = 2 * frame_units(c) * U + 20;
    for (int n = 0; n < total; n++) begin
      int r = region(c, n);
      if (r == 1)      tag = "R5/R7 lit";
      else if (r == 0) tag = "R6/R10 dark";
      else             tag = "R8 pause";
      if (retrig && n >= 100) tag = {tag, " R3 R9 after retrigger"};
      chk(tag, led, (r == 1), n);
      chk("R4 busy", busy, 1'b1, n);
      if (n == 100) begin
        // R3 / R9: new word and a new trigger must change nothing
        code_in = ~c;
        trig = retrig;
      end else if (n == 101) begin
        trig = 1'b0;
        code_in = $urandom;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    run_word(32'h0000_0000, 1'b0);
    run_word(32'hFFFF_FFFF, 1'b1);
    run_word(32'h8000_0001, 1'b1);
    run_word(32'h5A5A_A5A5, 1'b0);
    for (int t = 0; t < 2; t++) run_word($urandom, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule